// File: doc/BRIEF.md
# UART Interrupt Register Bank

This block keeps the interrupt bookkeeping for four UART event sources: transmit watermark, receive watermark, transmit empty and receive overflow. The UART datapath reports each event with a single-cycle pulse on a per-source set input. That pulse latches a sticky pending bit. Software sees the pending bits through a 32-bit word register port. It acknowledges events by writing ones to the pending word, and it chooses which events raise their interrupt line by writing a mask word. A third word lets software inject events for test. A write to that word ORs bits into the pending set, and the word always reads back as zero.

Each source has its own level interrupt output. An output is high while the pending bit and the mask bit of its source are both set. The outputs come straight from the registered pending and mask bits, so they change in the cycle after the write or event that caused the change.

Top module: `uart_irq_bank`

## Requirements
- R1: Reset clears the pending and mask registers and the read data, and drives all four interrupt lines low.
- R2: Bit positions are fixed: bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty, bit 3 is RX overflow. A pulse on set input bit i makes pending bit i read as 1 from the next cycle on. A read of the pending word (word address 0) returns the pending bits in bits 3:0 and zeros in bits 31:4.
- R3: A write to word address 0 clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to word address 2 ORs write-data bits 3:0 into the pending bits. Bits 31:4 of that write are ignored.
- R5: A read of word address 2 returns zero.
- R6: Word address 1 is the mask register. It is a read/write register over bits 3:0, and its bits 31:4 read as zero.
- R7: Interrupt line i is high exactly when pending bit i and mask bit i are both 1. The line reflects a register write or an event in the following cycle.
- R8: If a set pulse and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Word address 3 reads as zero, and writes to it change neither the pending nor the mask register.
- R10: Pending bits hold their value while no event and no write occur.
- R11: A read returns its data on rdata in the cycle after rd_en is sampled, and rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 4 | Per-source event pulses, bit order as in R2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 pending, 1 mask, 2 test, 3 unmapped |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_tx_wmark | output | 1 | TX watermark interrupt |
| irq_rx_wmark | output | 1 | RX watermark interrupt |
| irq_tx_empty | output | 1 | TX empty interrupt |
| irq_rx_ovf | output | 1 | RX overflow interrupt |

## Verification
The assertions assume that the strobes, the address, the write data and the event pulses are known values once reset is released. They also assume that a read and a write are not issued in the same cycle, so that a read never samples a register during its own update. The bench drives every input from tasks on the falling clock edge. Each task issues one operation at a time, and the event lines stay at zero except during a deliberate pulse. A scoreboard queue, fed by the read task, is compared against rdata one cycle after each read.

// File: rtl/uart_irq_bank.sv
`timescale 1ns/1ps
module uart_irq_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        evt_set,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_tx_wmark,
  output logic              irq_rx_wmark,
  output logic              irq_tx_empty,
  output logic              irq_rx_ovf
);
  localparam int NSRC = 4;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(2);

  logic [NSRC-1:0] pend, mask, clr_bits, tst_bits;
  logic unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:NSRC];
  assign clr_bits  = (wr_en && addr == A_PEND) ? wdata[NSRC-1:0] : '0;
  assign tst_bits  = (wr_en && addr == A_TEST) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~clr_bits) | tst_bits | evt_set;
      if (wr_en && addr == A_MASK) mask <= wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_PEND:  rdata <= DATA_W'(pend);
        A_MASK:  rdata <= DATA_W'(mask);
        default: rdata <= '0;
      endcase
    end
  end

  assign {irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark} = pend & mask;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((pend & $past(evt_set)) == $past(evt_set))); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PEND && (wdata[NSRC-1:0] & evt_set) == '0)
    |=> ((pend & $past(wdata[NSRC-1:0])) == '0)); // R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && evt_set == '0) |=> $stable(pend)); // R10
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (mask == $past(wdata[NSRC-1:0]))); // R6
  AST_TEST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_TEST) |=> (rdata == '0)); // R5
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata)); // R11
endmodule

// File: tb/tb_uart_irq_bank.sv
`timescale 1ns/1ps
module tb_uart_irq_bank;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] evt_set = '0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf;
  int checks = 0, errors = 0;
  bit done = 0, pend_rd = 0;
  logic [3:0] st = '0, en = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  uart_irq_bank dut (.clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_tx_wmark(irq_tx_wmark), .irq_rx_wmark(irq_rx_wmark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend_rd <= rd_en && rst_n;
  always @(negedge clk) if (pend_rd) begin
    if (exp_q.size() == 0) check("R11 unexpected read", rdata, 32'hx);
    else check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] ev);
    wr_en = 1; addr = a; wdata = d; evt_set = ev;
    @(negedge clk);
    wr_en = 0; evt_set = '0;
    case (a)
      2'd0: st = (st & ~d[3:0]) | ev;
      2'd1: begin en = d[3:0]; st = st | ev; end
      2'd2: st = st | d[3:0] | ev;
      default: st = st | ev;
    endcase
  endtask

  task automatic pulse(input logic [3:0] ev);
    evt_set = ev;
    @(negedge clk);
    evt_set = '0;
    st = st | ev;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, {28'd0, st & en});
  endtask

  task automatic do_reset();
    rst_n = 0; st = '0; en = '0;
    repeat (2) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'd0);
    chk_irq("R1 irq in reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    rd(2'd0, 32'd0, "R1 pending after reset");
    rd(2'd1, 32'd0, "R1 mask after reset");
    pulse(4'b0001); rd(2'd0, 32'h1, "R2 TX watermark bit0");
    pulse(4'b1000); rd(2'd0, 32'h9, "R2 RX overflow bit3");
    pulse(4'b0110); rd(2'd0, 32'hF, "R2 bits1,2");
    wr(2'd1, 32'hFFFF_FFF5, 4'd0); rd(2'd1, 32'h5, "R6 mask upper zero");
    chk_irq("R7 irq after mask write");
    wr(2'd0, 32'h3, 4'd0); chk_irq("R7 irq after clear");
    rd(2'd0, 32'hC, "R3 clear ones");
    wr(2'd0, 32'h0, 4'd0); rd(2'd0, 32'hC, "R3 zeros unchanged");
    wr(2'd2, 32'h2, 4'd0); rd(2'd0, 32'hE, "R4 test ORs in");
    wr(2'd1, 32'hA, 4'd0); chk_irq("R7 irq 1010");
    rd(2'd2, 32'd0, "R5 test reads zero");
    wr(2'd0, 32'h2, 4'b0010); rd(2'd0, 32'hE, "R8 set wins");
    wr(2'd3, 32'hF, 4'd0); rd(2'd3, 32'd0, "R9 unmapped reads zero");
    rd(2'd0, 32'hE, "R9 pending untouched"); rd(2'd1, 32'hA, "R9 mask untouched");
    repeat (5) @(negedge clk);
    rd(2'd0, 32'hE, "R10 sticky");
    check("R11 rdata holds", rdata, 32'hE);
    wr(2'd0, 32'hF, 4'd0); chk_irq("R7 all low after clear");
    wr(2'd2, 32'hFFFF_FFF0, 4'd0); rd(2'd0, 32'd0, "R4 upper bits ignored");
    wr(2'd1, 32'hF, 4'd0); pulse(4'b0100); chk_irq("R7 event raises line");
    do_reset();
    rd(2'd0, 32'd0, "R1 pending after second reset");
    rd(2'd1, 32'd0, "R1 mask after second reset");
    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule